// File: doc/BRIEF.md
# Iterative Integer Divider

This block is a multi-cycle divide unit for a 32-bit integer core. A one-cycle start request latches a dividend, a divisor and a signed/unsigned select. The quotient is returned in the LO result and the remainder in the HI result. Ordinary operands go through a shift-subtract loop that resolves one quotient bit per clock. A final cycle then restores the signs.

The block never raises an exception. Division by zero and the single signed overflow case (most-negative value divided by minus one) produce fixed HI/LO values. They are recognised when the request is accepted and are completed on the very next clock, without entering the loop. The surrounding pipeline watches the busy flag and the done pulse. It reads HI and LO, which keep the last completed result until another divide finishes.

Top module: `int_div_unit`

## Requirements
- R1: An unsigned divide with a non-zero divisor returns floor(dividend/divisor) on lo_o and dividend mod divisor on hi_o. Both operands are taken as 32-bit unsigned values.
- R2: A signed divide (signed_i=1) with a non-zero divisor, excluding the overflow case, treats operands as two's complement. The quotient on lo_o truncates toward zero, and the remainder on hi_o carries the sign of the dividend (or is zero).
- R3: An unsigned divide by zero gives lo_o=0xFFFFFFFF and hi_o equal to the dividend.
- R4: A signed divide by zero gives hi_o equal to the dividend. lo_o is 0x00000001 when the dividend is negative (bit 31 set) and 0xFFFFFFFF otherwise.
- R5: A signed divide of 0x80000000 by 0xFFFFFFFF gives lo_o=0x80000000 and hi_o=0.
- R6: A divide-by-zero or overflow request asserts done_o in the cycle right after the accepting clock edge, with the new hi_o/lo_o already valid. busy_o is never raised for it.
- R7: Any other request raises busy_o from the accepting edge for exactly 33 cycles (32 iterations plus sign fix-up). done_o is then high for one cycle with busy_o low and hi_o/lo_o valid. busy_o and done_o are never high together.
- R8: start_i while busy_o is high is ignored. The running divide finishes with its own operands and timing.
- R9: After reset hi_o, lo_o, busy_o and done_o are zero. hi_o and lo_o change only in the cycle where done_o is high, and otherwise hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a divide; accepted only when busy_o is low |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend, sampled on the accepting edge |
| divisor_i | input | 32 | Divisor, sampled on the accepting edge |
| busy_o | output | 1 | Iterative divide in progress |
| done_o | output | 1 | One-cycle pulse: new hi_o/lo_o valid |
| hi_o | output | 32 | Remainder of the last completed divide |
| lo_o | output | 32 | Quotient of the last completed divide |

## Verification
A wrong iteration count or a stuck state shows at the ports as a done_o pulse that comes early or late, or never comes. The directed tests catch this because they measure the cycle of done_o against the fixed 33-cycle window. A corrupted partial remainder or a quotient bit shifted into the wrong place shows up as a wrong HI/LO value once done_o rises. Edge operands such as 0xFFFFFFFF/1 and 0x80000000 as unsigned expose the top and bottom bits of this path. A misread sign flag affects only the signed cases, so each sign combination of dividend and divisor is run. A corner case wrongly routed into the loop shows within one cycle, as busy_o rising where done_o was due.

// File: rtl/int_div_pkg.sv
package int_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;

  function automatic logic [31:0] mag32(input logic [31:0] v, input logic neg);
    return neg ? (~v + 32'd1) : v;
  endfunction
endpackage

// File: rtl/int_div_corner.sv
module int_div_corner #(
  parameter int W = 32
) (
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         hit_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic zero_div, ovf;

  always_comb begin
    zero_div = (divisor_i == '0);
    ovf      = signed_i && (dividend_i == MOST_NEG) && (divisor_i == '1);
    hit_o    = zero_div || ovf;
    if (zero_div) begin
      hi_o = dividend_i;
      lo_o = (signed_i && dividend_i[W-1]) ? ONE : '1;
    end else begin
      hi_o = '0;
      lo_o = MOST_NEG;
    end
  end
endmodule

// File: rtl/int_div_iter.sv
module int_div_iter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] rem_q, quo_q, den_q;
  logic [W:0]   trial;

  assign trial = {rem_q, quo_q[W-1]} - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= num_i;
      den_q <= den_i;
    end else if (step_i) begin
      if (!trial[W]) begin
        rem_q <= trial[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= {rem_q[W-2:0], quo_q[W-1]};
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/int_div_signfix.sv
module int_div_signfix #(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_mag_i,
  input  logic [W-1:0] rem_mag_i,
  input  logic         neg_quo_i,
  input  logic         neg_rem_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  assign quo_o = neg_quo_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
  assign rem_o = neg_rem_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
endmodule

// File: rtl/int_div_unit.sv
module int_div_unit
  import int_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  div_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             neg_quo_q, neg_rem_q;
  logic             done_q;
  logic [W-1:0]     hi_q, lo_q;

  logic             accept;
  logic             corner_hit;
  logic [W-1:0]     corner_hi, corner_lo;
  logic             a_neg, b_neg;
  logic [W-1:0]     a_mag, b_mag;
  logic [W-1:0]     it_quo, it_rem;
  logic [W-1:0]     fx_quo, fx_rem;
  logic             load, step;

  assign accept = start_i && (state_q == ST_IDLE);
  assign a_neg  = signed_i && dividend_i[W-1];
  assign b_neg  = signed_i && divisor_i[W-1];
  assign a_mag  = a_neg ? (~dividend_i + 1'b1) : dividend_i;
  assign b_mag  = b_neg ? (~divisor_i + 1'b1) : divisor_i;
  assign load   = accept && !corner_hit;
  assign step   = (state_q == ST_RUN);

  int_div_corner #(.W(W)) u_corner (
    .signed_i  (signed_i),
    .dividend_i(dividend_i),
    .divisor_i (divisor_i),
    .hit_o     (corner_hit),
    .hi_o      (corner_hi),
    .lo_o      (corner_lo)
  );

  int_div_iter #(.W(W)) u_iter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(step),
    .num_i (a_mag),
    .den_i (b_mag),
    .quo_o (it_quo),
    .rem_o (it_rem)
  );

  int_div_signfix #(.W(W)) u_fix (
    .quo_mag_i(it_quo),
    .rem_mag_i(it_rem),
    .neg_quo_i(neg_quo_q),
    .neg_rem_i(neg_rem_q),
    .quo_o    (fx_quo),
    .rem_o    (fx_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
      done_q    <= 1'b0;
      hi_q      <= '0;
      lo_q      <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && corner_hit) begin
            hi_q   <= corner_hi;
            lo_q   <= corner_lo;
            done_q <= 1'b1;
          end else if (accept) begin
            state_q   <= ST_RUN;
            cnt_q     <= '0;
            neg_quo_q <= a_neg ^ b_neg;
            neg_rem_q <= a_neg;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX: begin
          hi_q    <= fx_rem;
          lo_q    <= fx_quo;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
endmodule

// File: rtl/int_div_unit_chk.sv
module int_div_unit_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         signed_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic        busy_d;
  logic [7:0]  run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_d  <= 1'b0;
      run_len <= '0;
    end else begin
      busy_d <= busy_o;
      if (busy_o && !busy_d) run_len <= 8'd1;
      else if (busy_o)       run_len <= run_len + 8'd1;
    end
  end

  a_r7_no_busy_and_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_run_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && busy_d) |-> (run_len == 8'(W + 1)));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(hi_o) && $stable(lo_o)));

  a_r6_corner_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (divisor_i == '0)) |=> (done_o && !busy_o));

  a_r3_udiv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !signed_i && (divisor_i == '0))
      |=> (lo_o == '1 && hi_o == $past(dividend_i)));

  a_r5_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && signed_i && dividend_i == MOST_NEG && divisor_i == '1)
      |=> (lo_o == MOST_NEG && hi_o == '0));

  a_r8_busy_keeps_going: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && run_len < 8'(W)) |=> busy_o);
endmodule

bind int_div_unit int_div_unit_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .signed_i  (signed_i),
  .dividend_i(dividend_i),
  .divisor_i (divisor_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .hi_o      (hi_o),
  .lo_o      (lo_o)
);

// File: tb/int_div_unit_test.sv
module int_div_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [31:0] divisor_i = '0;
  logic        busy_o, done_o;
  logic [31:0] hi_o, lo_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  int_div_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .signed_i(signed_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, input logic [31:0] b, input logic s,
                                output logic [31:0] hi, output logic [31:0] lo);
    int sa, sb;
    sa = a; sb = b;
    if (b == 0) begin
      hi = a;
      lo = (s && sa < 0) ? 32'h1 : 32'hFFFF_FFFF;
    end else if (s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      hi = 0; lo = 32'h8000_0000;
    end else if (s) begin
      lo = sa / sb; hi = sa % sb;
    end else begin
      lo = a / b; hi = a % b;
    end
  endfunction

  // Issue one divide, measure done latency, check busy and results.
  task automatic run_div(input string req, input logic [31:0] a, input logic [31:0] b,
                         input logic s, input bit corner, input bit poke_busy);
    logic [31:0] ehi, elo;
    int k;
    model(a, b, s, ehi, elo);
    @(negedge clk_i);
    start_i = 1'b1; signed_i = s; dividend_i = a; divisor_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    k = 1;
    check({req, " busy after start"}, {31'd0, busy_o}, corner ? 32'd0 : 32'd1);
    while (!done_o && k < 60) begin
      if (poke_busy && k == 5) begin
        start_i = 1'b1; signed_i = 1'b0; dividend_i = 32'd100; divisor_i = 32'd7;
      end else begin
        start_i = 1'b0;
        if (!corner) check({req, " busy during run"}, {31'd0, busy_o}, 32'd1);
      end
      @(negedge clk_i);
      k++;
    end
    start_i = 1'b0;
    check({req, " done latency"}, k, corner ? 32'd1 : 32'd34);
    check({req, " busy at done"}, {31'd0, busy_o}, 32'd0);
    check({req, " lo"}, lo_o, elo);
    check({req, " hi"}, hi_o, ehi);
    @(negedge clk_i);
    check({req, " done single"}, {31'd0, done_o}, 32'd0);
  endtask

  task automatic t_reset();
    check("R9 reset hi", hi_o, 32'd0);
    check("R9 reset lo", lo_o, 32'd0);
    check("R9 reset busy", {31'd0, busy_o}, 32'd0);
    check("R9 reset done", {31'd0, done_o}, 32'd0);
  endtask

  task automatic t_hold();
    logic [31:0] h, l;
    h = hi_o; l = lo_o;
    repeat (6) @(negedge clk_i);
    check("R9 hold hi", hi_o, h);
    check("R9 hold lo", lo_o, l);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    run_div("R1 udiv", 32'd1000, 32'd7, 1'b0, 1'b0, 1'b0);
    run_div("R1 udiv max/1", 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0);
    run_div("R1 udiv msb", 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    run_div("R1 udiv small/large", 32'd5, 32'hF000_0000, 1'b0, 1'b0, 1'b0);
    run_div("R2 sdiv ++", 32'd17, 32'd5, 1'b1, 1'b0, 1'b0);
    run_div("R2 sdiv -+", -32'sd17, 32'd5, 1'b1, 1'b0, 1'b0);
    run_div("R2 sdiv +-", 32'd17, -32'sd5, 1'b1, 1'b0, 1'b0);
    run_div("R2 sdiv --", -32'sd17, -32'sd5, 1'b1, 1'b0, 1'b0);
    run_div("R2 sdiv minneg/2", 32'h8000_0000, 32'd2, 1'b1, 1'b0, 1'b0);
    run_div("R3 udiv zero", 32'h1234_5678, 32'd0, 1'b0, 1'b1, 1'b0);
    run_div("R3 udiv zero neg-looking", 32'h9000_0001, 32'd0, 1'b0, 1'b1, 1'b0);
    run_div("R4 sdiv zero pos", 32'd42, 32'd0, 1'b1, 1'b1, 1'b0);
    run_div("R4 sdiv zero neg", 32'hFFFF_FFF0, 32'd0, 1'b1, 1'b1, 1'b0);
    run_div("R5 R6 overflow", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);
    t_hold();
    run_div("R8 start while busy", 32'd999, 32'd10, 1'b0, 1'b0, 1'b1);
    run_div("R7 back to back", 32'd77, 32'd0, 1'b1, 1'b1, 1'b0);
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule